// File: doc/BRIEF.md
# Single-Cycle Word Core

This block is a small 32-bit processor that completes one instruction on every clock edge while its `run` input is high. It covers a narrow slice of a classic load/store instruction set: four register-to-register operations (add, subtract, bitwise and, bitwise or), a word load, a word store, a compare-and-branch on equality, and an absolute jump. It holds a program counter, thirty-two 32-bit general registers, a field decoder, an ALU and the next-PC logic. It also holds two word-wide memories of its own, one for instructions and one for data.

Programs and initial data come in through a single load stream. A beat is a `ld_valid`/`ld_ready` handshake that carries one 32-bit word, a word index, and a flag that picks the instruction or the data memory. The core gives back-pressure by holding `ld_ready` low for every cycle in which `run` is high. While that is so, a held `ld_valid` writes nothing, and the sender keeps the beat until `ld_ready` returns. Two plain debug outputs show the current PC and one register, chosen by `dbg_sel`. A testbench uses them to follow the architectural state instruction by instruction.

Top module: `wc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the PC to 0 and clears every general register to 0. Memory contents are kept.
- R2: Opcode field bits 31:26 equal to 0 selects a register operation. The fields are rs = bits 25:21, rt = bits 20:16, rd = bits 15:11, and funct = bits 5:0. Funct 32 writes rs+rt to rd, 34 writes rs−rt, 36 writes rs AND rt, and 37 writes rs OR rt.
- R3: Register 0 reads as zero on every port, and any write aimed at it is dropped.
- R4: Opcode 35 loads the data word at byte address rs + sign-extended bits 15:0 into rt. The word index is address bits [DMEM_AW+1:2], so the two low address bits are ignored.
- R5: Opcode 43 stores rt to the data word chosen exactly as in R4.
- R6: Opcode 4 compares rs with rt. On equality the next PC is PC+4+4×(sign-extended bits 15:0); otherwise it is PC+4.
- R7: Opcode 2 makes the next PC the current PC bits 31:28 followed by bits 25:0 of the instruction and two zero bits.
- R8: Any other opcode, or opcode 0 with any other funct, changes no register and no memory, and only advances the PC by 4.
- R9: A load beat is taken on a clock edge where `ld_valid` and `ld_ready` are both high. `ld_ready` equals the inverse of `run`. `ld_to_data` = 0 writes instruction word `ld_addr`, and 1 writes data word `ld_addr`.
- R10: With `run` low, the PC and the registers do not change.
- R11: `dbg_pc` shows the current PC and `dbg_reg` shows register `dbg_sel`, both without delay. The instruction fetched is the instruction word at PC bits [IMEM_AW+1:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Execute one instruction per edge while high |
| ld_valid | input | 1 | Load stream beat present |
| ld_ready | output | 1 | Load stream may be accepted (high while idle) |
| ld_to_data | input | 1 | 0 targets instruction memory, 1 targets data memory |
| ld_addr | input | LD_AW | Word index of the load beat |
| ld_word | input | 32 | Word carried by the load beat |
| dbg_sel | input | 5 | Register number shown on `dbg_reg` |
| dbg_reg | output | 32 | Contents of the selected register |
| dbg_pc | output | 32 | Current program counter |

## Verification
Both the load stream and execution can write the memories, and they can fall in the same cycle. The bench provokes this by raising `ld_valid` together with `run`. The beat targets the very instruction word being executed, and its payload is a jump. The result is judged by three things: `ld_ready` is low during the overlap, the original load completes into its register with the PC at 4, and a rerun from reset executes the original instruction again, not the jump.

// File: rtl/wc_pkg.sv
package wc_pkg;

  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);

  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_JMP  = 6'd2;
  localparam logic [5:0] OP_BEQ  = 6'd4;
  localparam logic [5:0] OP_LDW  = 6'd35;
  localparam logic [5:0] OP_STW  = 6'd43;

  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_SUB  = 6'd34;
  localparam logic [5:0] FN_AND  = 6'd36;
  localparam logic [5:0] FN_OR   = 6'd37;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR
  } alu_op_e;

  typedef struct packed {
    logic [5:0]        op;
    logic [RIDX_W-1:0] rs;
    logic [RIDX_W-1:0] rt;
    logic [RIDX_W-1:0] rd;
    logic [5:0]        funct;
    logic [15:0]       imm;
    logic [25:0]       jidx;
  } fields_t;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    mem_rd;
    logic    mem_we;
    logic    branch;
    logic    jump;
    logic    src_imm;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/wc_decode.sv
module wc_decode
  import wc_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output fields_t         fld,
  output ctrl_t           ctl
);

  always_comb begin
    fld.op    = instr[31:26];
    fld.rs    = instr[25:21];
    fld.rt    = instr[20:16];
    fld.rd    = instr[15:11];
    fld.funct = instr[5:0];
    fld.imm   = instr[15:0];
    fld.jidx  = instr[25:0];
  end

  always_comb begin
    ctl = '{reg_we: 1'b0, dst_rd: 1'b0, mem_rd: 1'b0, mem_we: 1'b0,
            branch: 1'b0, jump: 1'b0, src_imm: 1'b0, alu_op: ALU_ADD};
    unique case (fld.op)
      OP_REG: begin
        ctl.dst_rd = 1'b1;
        unique case (fld.funct)
          FN_ADD:  begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_ADD; end
          FN_SUB:  begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_SUB; end
          FN_AND:  begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_AND; end
          FN_OR:   begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_OR;  end
          default: ctl.reg_we = 1'b0;
        endcase
      end
      OP_LDW: begin
        ctl.reg_we  = 1'b1;
        ctl.mem_rd  = 1'b1;
        ctl.src_imm = 1'b1;
      end
      OP_STW: begin
        ctl.mem_we  = 1'b1;
        ctl.src_imm = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      OP_JMP:  ctl.jump = 1'b1;
      default: ctl.jump = 1'b0;
    endcase
  end

endmodule

// File: rtl/wc_alu.sv
module wc_alu
  import wc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/wc_regfile.sv
module wc_regfile #(
  parameter int W    = 32,
  parameter int N    = 32,
  localparam int IW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [IW-1:0] ra1,
  input  logic [IW-1:0] ra2,
  input  logic [IW-1:0] ra3,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  output logic [W-1:0]  rd3
);

  logic [W-1:0] regs [N];
  logic [IW-1:0] raddr [3];
  logic [W-1:0]  rdata [3];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign raddr[0] = ra1;
  assign raddr[1] = ra2;
  assign raddr[2] = ra3;

  for (genvar p = 0; p < 3; p++) begin : g_rport
    assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
  end

  assign rd1 = rdata[0];
  assign rd2 = rdata[1];
  assign rd3 = rdata[2];

endmodule

// File: rtl/wc_mem.sv
module wc_mem #(
  parameter int W  = 32,
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/wc_nextpc.sv
module wc_nextpc #(
  parameter int W = 32
) (
  input  logic [W-1:0] pc,
  input  logic [15:0]  imm,
  input  logic [25:0]  jidx,
  input  logic         take_branch,
  input  logic         jump,
  output logic [W-1:0] pc_next
);

  logic [W-1:0] seq;
  logic [W-1:0] boff;

  assign seq  = pc + W'(4);
  assign boff = {{(W-18){imm[15]}}, imm, 2'b00};

  always_comb begin
    if (jump)             pc_next = {pc[W-1:W-4], jidx, 2'b00};
    else if (take_branch) pc_next = seq + boff;
    else                  pc_next = seq;
  end

endmodule

// File: rtl/wc_core.sv
module wc_core
  import wc_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  localparam int LD_AW  = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic              ld_to_data,
  input  logic [LD_AW-1:0]  ld_addr,
  input  logic [XLEN-1:0]   ld_word,
  input  logic [RIDX_W-1:0] dbg_sel,
  output logic [XLEN-1:0]   dbg_reg,
  output logic [XLEN-1:0]   dbg_pc
);

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_next;
  logic [XLEN-1:0] instr;
  fields_t         fld;
  ctrl_t           ctl;
  logic            exec;
  logic            ld_fire;

  logic [XLEN-1:0] rs_val;
  logic [XLEN-1:0] rt_val;
  logic [XLEN-1:0] alu_b;
  logic [XLEN-1:0] alu_y;
  logic            alu_zero;
  logic [XLEN-1:0] dmem_q;

  logic               rf_we;
  logic [RIDX_W-1:0]  rf_wa;
  logic [XLEN-1:0]    rf_wd;

  logic               im_we;
  logic               dm_we;
  logic [DMEM_AW-1:0] dm_waddr;
  logic [XLEN-1:0]    dm_wdata;

  // execution and loading are mutually exclusive through ld_ready
  assign exec     = run & ~rst;
  assign ld_ready = ~run;
  assign ld_fire  = ld_valid & ld_ready;

  always_ff @(posedge clk) begin
    if (rst)       pc_q <= '0;
    else if (exec) pc_q <= pc_next;
  end

  assign im_we = ld_fire & ~ld_to_data;

  wc_mem #(.W(XLEN), .AW(IMEM_AW)) u_imem (
    .clk   (clk),
    .we    (im_we),
    .waddr (ld_addr[IMEM_AW-1:0]),
    .wdata (ld_word),
    .raddr (pc_q[IMEM_AW+1:2]),
    .rdata (instr)
  );

  wc_decode u_dec (
    .instr (instr),
    .fld   (fld),
    .ctl   (ctl)
  );

  assign rf_we = exec & ctl.reg_we;
  assign rf_wa = ctl.dst_rd ? fld.rd : fld.rt;
  assign rf_wd = ctl.mem_rd ? dmem_q : alu_y;

  wc_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk (clk),
    .rst (rst),
    .we  (rf_we),
    .wa  (rf_wa),
    .wd  (rf_wd),
    .ra1 (fld.rs),
    .ra2 (fld.rt),
    .ra3 (dbg_sel),
    .rd1 (rs_val),
    .rd2 (rt_val),
    .rd3 (dbg_reg)
  );

  assign alu_b = ctl.src_imm ? {{(XLEN-16){fld.imm[15]}}, fld.imm} : rt_val;

  wc_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (ctl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // one data write port shared by stores and load-stream beats
  assign dm_we    = (exec & ctl.mem_we) | (ld_fire & ld_to_data);
  assign dm_waddr = exec ? alu_y[DMEM_AW+1:2] : ld_addr[DMEM_AW-1:0];
  assign dm_wdata = exec ? rt_val : ld_word;

  wc_mem #(.W(XLEN), .AW(DMEM_AW)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (alu_y[DMEM_AW+1:2]),
    .rdata (dmem_q)
  );

  wc_nextpc #(.W(XLEN)) u_npc (
    .pc          (pc_q),
    .imm         (fld.imm),
    .jidx        (fld.jidx),
    .take_branch (ctl.branch & alu_zero),
    .jump        (ctl.jump),
    .pc_next     (pc_next)
  );

  assign dbg_pc = pc_q;

endmodule

// File: rtl/wc_check.sv
module wc_check
  import wc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic [XLEN-1:0]   pc,
  input logic [XLEN-1:0]   instr,
  input logic [RIDX_W-1:0] dbg_sel,
  input logic [XLEN-1:0]   dbg_reg
);

  logic [5:0] op;
  logic       op_known;
  logic       rst_d;

  assign op = instr[31:26];
  assign op_known = (op == OP_REG) || (op == OP_JMP) || (op == OP_BEQ) ||
                    (op == OP_LDW) || (op == OP_STW);

  always_ff @(posedge clk) rst_d <= rst;

  always @(negedge clk) begin
    if (rst_d === 1'b1) begin
      p_pc_cleared_r1: assert (pc == '0);
    end
  end

  p_zero_reg_r3: assert property (@(posedge clk) disable iff (rst)
    (dbg_sel == '0) |-> (dbg_reg == '0));

  p_pc_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  p_jump_target_r7: assert property (@(posedge clk) disable iff (rst)
    (run && op == OP_JMP) |=> (pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00}));

  p_undef_step_r8: assert property (@(posedge clk) disable iff (rst)
    (run && !op_known) |=> (pc == $past(pc) + 32'd4));

  p_pc_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(pc));

endmodule

bind wc_core wc_check u_chk (
  .clk     (clk),
  .rst     (rst),
  .run     (run),
  .pc      (pc_q),
  .instr   (instr),
  .dbg_sel (dbg_sel),
  .dbg_reg (dbg_reg)
);

// File: tb/tb_wc_core.sv
module tb_wc_core;

  localparam int CLK_PERIOD = 10;
  localparam int LD_AW = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              run = 1'b0;
  logic              ld_valid = 1'b0;
  logic              ld_ready;
  logic              ld_to_data = 1'b0;
  logic [LD_AW-1:0]  ld_addr = '0;
  logic [31:0]       ld_word = '0;
  logic [4:0]        dbg_sel = '0;
  logic [31:0]       dbg_reg;
  logic [31:0]       dbg_pc;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wc_core dut (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .ld_valid   (ld_valid),
    .ld_ready   (ld_ready),
    .ld_to_data (ld_to_data),
    .ld_addr    (ld_addr),
    .ld_word    (ld_word),
    .dbg_sel    (dbg_sel),
    .dbg_reg    (dbg_reg),
    .dbg_pc     (dbg_pc)
  );

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [4:0] rd);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(input logic [25:0] idx);
    return {6'd2, idx};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    run = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic put(input bit to_data, input int addr, input logic [31:0] w);
    @(negedge clk);
    ld_valid   = 1'b1;
    ld_to_data = to_data;
    ld_addr    = LD_AW'(addr);
    ld_word    = w;
    @(negedge clk);
    ld_valid   = 1'b0;
  endtask

  task automatic step(input int n);
    @(negedge clk);
    run = 1'b1;
    repeat (n) @(negedge clk);
    run = 1'b0;
  endtask

  task automatic chk_reg(input string tag, input logic [4:0] r, input logic [31:0] exp);
    dbg_sel = r;
    #1;
    chk(tag, dbg_reg, exp);
  endtask

  // R2 R3 R11: four register operations and register zero
  task automatic t_arith();
    do_reset();
    put(1, 0, 32'h0000_1234);
    put(1, 1, 32'hFFFF_0F0F);
    put(0, 0, enc_i(6'd35, 5'd0, 5'd9, 16'd0));
    put(0, 1, enc_i(6'd35, 5'd0, 5'd22, 16'd4));
    put(0, 2, enc_r(6'd32, 5'd9, 5'd22, 5'd3));
    put(0, 3, enc_r(6'd34, 5'd9, 5'd22, 5'd4));
    put(0, 4, enc_r(6'd36, 5'd9, 5'd22, 5'd5));
    put(0, 5, enc_r(6'd37, 5'd9, 5'd22, 5'd31));
    put(0, 6, enc_r(6'd32, 5'd9, 5'd22, 5'd0));
    put(0, 7, enc_r(6'd32, 5'd0, 5'd22, 5'd7));
    put(0, 8, enc_i(6'd35, 5'd0, 5'd0, 16'd0));
    step(9);
    chk("R11 pc after nine", dbg_pc, 32'd36);
    chk_reg("R2 add", 5'd3, 32'hFFFF_2143);
    chk_reg("R2 sub", 5'd4, 32'h0001_0325);
    chk_reg("R2 and", 5'd5, 32'h0000_0204);
    chk_reg("R2 or", 5'd31, 32'hFFFF_1F3F);
    chk_reg("R3 r0 write dropped", 5'd0, 32'h0);
    chk_reg("R3 r0 reads zero", 5'd7, 32'hFFFF_0F0F);
  endtask

  // R1: reset clears PC and registers
  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 pc", dbg_pc, 32'h0);
    chk_reg("R1 reg3", 5'd3, 32'h0);
    chk_reg("R1 reg31", 5'd31, 32'h0);
  endtask

  // R4 R5: negative offsets, ignored low address bits, store then load
  task automatic t_mem();
    do_reset();
    put(1, 2, 32'd16);
    put(1, 3, 32'hCAFE_F00D);
    put(0, 0, enc_i(6'd35, 5'd0, 5'd10, 16'd8));
    put(0, 1, enc_i(6'd35, 5'd10, 5'd11, 16'hFFFC));
    put(0, 2, enc_i(6'd35, 5'd10, 5'd12, 16'hFFFE));
    put(0, 3, enc_i(6'd43, 5'd0, 5'd11, 16'd20));
    put(0, 4, enc_i(6'd35, 5'd0, 5'd13, 16'd20));
    put(0, 5, enc_i(6'd43, 5'd10, 5'd12, 16'd1));
    put(0, 6, enc_i(6'd35, 5'd0, 5'd14, 16'd16));
    step(7);
    chk("R4 pc", dbg_pc, 32'd28);
    chk_reg("R4 negative offset", 5'd11, 32'hCAFE_F00D);
    chk_reg("R4 unaligned low bits", 5'd12, 32'hCAFE_F00D);
    chk_reg("R5 store aligned", 5'd13, 32'hCAFE_F00D);
    chk_reg("R5 store unaligned", 5'd14, 32'hCAFE_F00D);
  endtask

  // R6: taken forward, not taken, taken backward
  task automatic t_branch();
    do_reset();
    put(1, 0, 32'h0000_1234);
    put(0, 0, enc_i(6'd35, 5'd0, 5'd1, 16'd0));
    put(0, 1, enc_i(6'd35, 5'd0, 5'd2, 16'd0));
    put(0, 2, enc_i(6'd4, 5'd1, 5'd2, 16'd3));
    put(0, 6, enc_i(6'd4, 5'd1, 5'd0, 16'd5));
    put(0, 7, enc_i(6'd4, 5'd0, 5'd0, 16'hFFFC));
    step(3);
    chk("R6 taken forward", dbg_pc, 32'd24);
    step(1);
    chk("R6 not taken", dbg_pc, 32'd28);
    step(1);
    chk("R6 taken backward", dbg_pc, 32'd16);
  endtask

  // R7 R11: full-width jump field, then wrapped fetch jumps back
  task automatic t_jump();
    do_reset();
    put(0, 0, enc_j(26'h3FF_FFFF));
    put(0, 63, enc_j(26'd2));
    step(1);
    chk("R7 jump max field", dbg_pc, 32'h0FFF_FFFC);
    step(1);
    chk("R7 R11 wrapped fetch jump", dbg_pc, 32'd8);
  endtask

  // R8: undefined opcode and funct do nothing but advance
  task automatic t_undef();
    do_reset();
    put(1, 0, 32'h0000_1234);
    put(0, 0, enc_i(6'd35, 5'd0, 5'd5, 16'd0));
    put(0, 1, 32'hFC00_0000 | enc_r(6'd0, 5'd5, 5'd5, 5'd5));
    put(0, 2, enc_r(6'h2A, 5'd5, 5'd5, 5'd5));
    put(0, 3, enc_i(6'd41, 5'd0, 5'd0, 16'd0));
    put(0, 4, enc_i(6'd35, 5'd0, 5'd6, 16'd0));
    step(4);
    chk("R8 pc steps by four", dbg_pc, 32'd16);
    chk_reg("R8 register untouched", 5'd5, 32'h0000_1234);
    step(1);
    chk_reg("R8 memory untouched", 5'd6, 32'h0000_1234);
  endtask

  // R9 R10: back-pressure while running, hold while idle
  task automatic t_stream();
    do_reset();
    put(1, 0, 32'h0000_1234);
    put(0, 0, enc_i(6'd35, 5'd0, 5'd20, 16'd0));
    #1;
    chk("R9 ready when idle", {31'd0, ld_ready}, 32'd1);
    @(negedge clk);
    run        = 1'b1;
    ld_valid   = 1'b1;
    ld_to_data = 1'b0;
    ld_addr    = '0;
    ld_word    = enc_j(26'd5);
    #1;
    chk("R9 not ready while running", {31'd0, ld_ready}, 32'd0);
    @(negedge clk);
    run      = 1'b0;
    ld_valid = 1'b0;
    #1;
    chk("R9 original instruction ran", dbg_pc, 32'd4);
    chk_reg("R9 original load result", 5'd20, 32'h0000_1234);
    repeat (5) @(negedge clk);
    chk("R10 pc holds", dbg_pc, 32'd4);
    chk_reg("R10 register holds", 5'd20, 32'h0000_1234);
    do_reset();
    step(1);
    chk("R9 beat dropped in memory", dbg_pc, 32'd4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_arith();
    t_reset();
    t_mem();
    t_branch();
    t_jump();
    t_undef();
    t_stream();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule